// File: doc/BRIEF.md
# Angle Freeze and Byte Readout

This block sits between an angle word that a tracking converter refreshes continuously and an 8-bit data bus shared with other devices. The live angle is captured whenever its valid strobe is high, whether or not a host is reading. A host that wants a consistent value raises a hold request. After a programmable number of clocks, the output copy of the angle stops following the live word. The live word keeps tracking throughout, so the upstream path never waits.

The host reads the frozen copy as two bytes, each with its own active-low enable. The high byte is always the top eight angle bits. The low byte holds the remaining bits for the selected resolution, left-justified. Each enable has its own turn-on and turn-off latency in clock cycles. A per-bit output-enable vector takes the place of a tri-state driver. A sticky flag records any cycle in which both enables were low together.

Top module: `angle_freeze_readout`

## Requirements
- R1: The live angle register loads `ang_in` on every clock where `ang_vld` is high, including while the output copy is frozen. After release, the reads return the last word strobed during the hold.
- R2: While the copy is open, the held word equals the live word of the previous clock.
- R3: While the copy is frozen, the held word does not change, however long `hold_req` stays high.
- R4: `hold_req` passes through a chain of `FREEZE_DLY` registers before it freezes the copy. A `hold_req` first sampled at edge k leaves edge k+FREEZE_DLY-1 as the last edge at which the copy still loads. Release reopens the copy after the same delay.
- R5: When the high-byte driver is active, `bus_out` carries bits [15:8] of the held word.
- R6: When only the low-byte driver is active, `bus_out` carries bits [7:0] of the held word ANDed with a mask. The mask keeps the top 2, 4, 6 or 8 bits for `res_sel` = 0, 1, 2, 3 (total resolution 10, 12, 14, 16 bits).
- R7: `bus_oe` is either all ones or all zeros. It is all zeros, with `bus_out` zero, when no driver is active.
- R8: A driver turns on after its enable has been sampled low on `EN_DLY` consecutive edges. It turns off after its enable has been sampled high on `DIS_DLY` consecutive edges.
- R9: If both drivers are active, the high byte is driven. `conflict` sets one clock after any edge that samples both enables low, and it stays set until reset.
- R10: A live word strobed at the last open edge is excluded whole. The frozen copy equals the word strobed at the edge before it.
- R11: Synchronous reset clears the live and held words to zero, opens the copy, turns both drivers off (`bus_oe` = 0) and clears `conflict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ang_in | input | ANGLE_W | Live angle word, bit 15 most significant |
| ang_vld | input | 1 | Strobe that loads `ang_in` |
| hold_req | input | 1 | Active-high request to freeze the output copy |
| res_sel | input | 2 | Resolution: 0=10, 1=12, 2=14, 3=16 bits |
| msb_en_n | input | 1 | Active-low enable for the high byte |
| lsb_en_n | input | 1 | Active-low enable for the low byte |
| bus_out | output | 8 | Byte driven toward the shared bus |
| bus_oe | output | 8 | Per-bit output enable, 1 = driving |
| conflict | output | 1 | Sticky flag: both enables were low together |

## Verification
The hardest case to reach is a live word arriving on exactly the edge where the copy closes. The bench raises `hold_req` and then strobes a distinct word on each of the following edges. The frozen value then shows which edge was the last to load. A delay one longer or shorter, or a partly updated word, gives a different byte pair. The bench then keeps the hold for hundreds of cycles with the live word changing on every clock, and checks that the release exposes the last tracked word.

// File: rtl/angrd_pkg.sv
package angrd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RES_10 = 2'd0,
    RES_12 = 2'd1,
    RES_14 = 2'd2,
    RES_16 = 2'd3
  } res_e;

  function automatic logic [BYTE_W-1:0] lo_mask(input res_e r);
    case (r)
      RES_10:  lo_mask = 8'hC0;
      RES_12:  lo_mask = 8'hF0;
      RES_14:  lo_mask = 8'hFC;
      default: lo_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/angrd_freeze.sv
module angrd_freeze #(
  parameter int ANGLE_W    = 16,
  parameter int FREEZE_DLY = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ANGLE_W-1:0] ang_in,
  input  logic               ang_vld,
  input  logic               hold_req,
  output logic [ANGLE_W-1:0] live,
  output logic [ANGLE_W-1:0] held,
  output logic               frozen
);
  logic [FREEZE_DLY-1:0] chain;

  generate
    if (FREEZE_DLY == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= hold_req;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[FREEZE_DLY-2:0], hold_req};
      end
    end
  endgenerate

  assign frozen = chain[FREEZE_DLY-1];

  // The copy loads a complete registered word or nothing at all.
  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      held <= '0;
    end else begin
      if (ang_vld) live <= ang_in;
      if (!frozen) held <= live;
    end
  end
endmodule

// File: rtl/angrd_drv.sv
module angrd_drv #(
  parameter int ON_DLY  = 2,
  parameter int OFF_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en_n,
  output logic drive
);
  localparam int MAXD = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  logic          act;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign act    = ~en_n;
  assign lim_m1 = act ? CW'(ON_DLY - 1) : CW'(OFF_DLY - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      drive <= 1'b0;
      cnt   <= '0;
    end else if (act != drive) begin
      if (cnt == lim_m1) begin
        drive <= act;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/angrd_bytesel.sv
module angrd_bytesel
  import angrd_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic [ANGLE_W-1:0] held,
  input  res_e               res,
  input  logic               drv_hi,
  input  logic               drv_lo,
  output logic [BYTE_W-1:0]  data,
  output logic [BYTE_W-1:0]  oe
);
  localparam int LO_TOP = ANGLE_W - BYTE_W - 1;

  logic [BYTE_W-1:0] hi_byte;
  logic [BYTE_W-1:0] lo_byte;

  assign hi_byte = held[ANGLE_W-1 -: BYTE_W];
  assign lo_byte = held[LO_TOP -: BYTE_W] & lo_mask(res);

  always_comb begin
    if (drv_hi) begin
      data = hi_byte;
      oe   = '1;
    end else if (drv_lo) begin
      data = lo_byte;
      oe   = '1;
    end else begin
      data = '0;
      oe   = '0;
    end
  end
endmodule

// File: rtl/angle_freeze_readout.sv
module angle_freeze_readout
  import angrd_pkg::*;
#(
  parameter int ANGLE_W    = 16,
  parameter int FREEZE_DLY = 3,
  parameter int EN_DLY     = 2,
  parameter int DIS_DLY    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ANGLE_W-1:0] ang_in,
  input  logic               ang_vld,
  input  logic               hold_req,
  input  logic [1:0]         res_sel,
  input  logic               msb_en_n,
  input  logic               lsb_en_n,
  output logic [7:0]         bus_out,
  output logic [7:0]         bus_oe,
  output logic               conflict
);
  logic [ANGLE_W-1:0] live;
  logic [ANGLE_W-1:0] held;
  logic               frozen;
  logic [1:0]         drv;
  logic [1:0]         en_n_vec;

  angrd_freeze #(
    .ANGLE_W   (ANGLE_W),
    .FREEZE_DLY(FREEZE_DLY)
  ) u_freeze (
    .clk     (clk),
    .rst     (rst),
    .ang_in  (ang_in),
    .ang_vld (ang_vld),
    .hold_req(hold_req),
    .live    (live),
    .held    (held),
    .frozen  (frozen)
  );

  assign en_n_vec = {msb_en_n, lsb_en_n};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_drv
      angrd_drv #(
        .ON_DLY (EN_DLY),
        .OFF_DLY(DIS_DLY)
      ) u_drv (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_n_vec[i]),
        .drive(drv[i])
      );
    end
  endgenerate

  angrd_bytesel #(
    .ANGLE_W(ANGLE_W)
  ) u_sel (
    .held  (held),
    .res   (res_e'(res_sel)),
    .drv_hi(drv[1]),
    .drv_lo(drv[0]),
    .data  (bus_out),
    .oe    (bus_oe)
  );

  always_ff @(posedge clk) begin
    if (rst)                        conflict <= 1'b0;
    else if (!msb_en_n && !lsb_en_n) conflict <= 1'b1;
  end
endmodule

// File: rtl/angrd_chk.sv
module angrd_chk #(
  parameter int ANGLE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               msb_en_n,
  input logic               lsb_en_n,
  input logic [7:0]         bus_oe,
  input logic               conflict,
  input logic               frozen,
  input logic [ANGLE_W-1:0] live,
  input logic [ANGLE_W-1:0] held
);
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_oe == '0 && !conflict && held == '0));

  p_open_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !frozen |=> held == $past(live));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(held));

  p_whole_capture_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen) |-> held == $past(live));

  p_oe_uniform_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_oe == '0) || (bus_oe == '1));

  p_conflict_set_r9: assert property (@(posedge clk) disable iff (rst)
    (!msb_en_n && !lsb_en_n) |=> conflict);

  p_conflict_keep_r9: assert property (@(posedge clk) disable iff (rst)
    conflict |=> conflict);
endmodule

bind angle_freeze_readout angrd_chk #(.ANGLE_W(ANGLE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .msb_en_n(msb_en_n),
  .lsb_en_n(lsb_en_n),
  .bus_oe  (bus_oe),
  .conflict(conflict),
  .frozen  (frozen),
  .live    (live),
  .held    (held)
);

// File: tb/tb_angle_freeze_readout.sv
`timescale 1ns/1ps
module tb_angle_freeze_readout;
  localparam int FD  = 3;
  localparam int EN  = 2;
  localparam int DIS = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ang_in = '0;
  logic        ang_vld = 1'b0;
  logic        hold_req = 1'b0;
  logic [1:0]  res_sel = 2'd3;
  logic        msb_en_n = 1'b1;
  logic        lsb_en_n = 1'b1;
  logic [7:0]  bus_out;
  logic [7:0]  bus_oe;
  logic        conflict;

  int checks = 0;
  int fails  = 0;

  angle_freeze_readout #(
    .ANGLE_W(16), .FREEZE_DLY(FD), .EN_DLY(EN), .DIS_DLY(DIS)
  ) dut (
    .clk(clk), .rst(rst), .ang_in(ang_in), .ang_vld(ang_vld),
    .hold_req(hold_req), .res_sel(res_sel), .msb_en_n(msb_en_n),
    .lsb_en_n(lsb_en_n), .bus_out(bus_out), .bus_oe(bus_oe),
    .conflict(conflict)
  );

  always #10 clk = ~clk;

  // Behavioural reference model
  logic [15:0] m_live, m_held;
  int          m_hist[FD];
  int          m_cnt[2];
  bit          m_drv[2];
  bit          m_conf;
  bit          m_act;

  always @(posedge clk) begin
    if (rst) begin
      m_live = '0; m_held = '0; m_conf = 0;
      for (int i = 0; i < FD; i++) m_hist[i] = 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_drv[i] = 0; end
    end else begin
      if (m_hist[FD-1] == 0) m_held = m_live;
      if (ang_vld) m_live = ang_in;
      for (int i = FD-1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = hold_req ? 1 : 0;
      for (int i = 0; i < 2; i++) begin
        m_act = (i == 0) ? !msb_en_n : !lsb_en_n;
        if (m_act != m_drv[i]) begin
          m_cnt[i]++;
          if (m_cnt[i] == (m_act ? EN : DIS)) begin
            m_drv[i] = m_act; m_cnt[i] = 0;
          end
        end else m_cnt[i] = 0;
      end
      if (!msb_en_n && !lsb_en_n) m_conf = 1;
    end
  end

  function automatic logic [7:0] mask_of(input logic [1:0] r);
    int keep = 2 + 2 * int'(r);
    return 8'(8'hFF << (8 - keep));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison in the middle of the high phase
  logic [7:0] e_oe, e_d;
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      e_oe = (m_drv[0] || m_drv[1]) ? 8'hFF : 8'h00;
      e_d  = m_drv[0] ? m_held[15:8] :
             m_drv[1] ? (m_held[7:0] & mask_of(res_sel)) : 8'h00;
      chk(bus_oe == e_oe, "R8", "bus_oe per cycle", 16'(bus_oe), 16'(e_oe));
      chk(bus_out == e_d, m_drv[0] ? "R5" : "R6", "bus_out per cycle",
          16'(bus_out), 16'(e_d));
      chk(conflict == m_conf, "R9", "conflict per cycle",
          16'(conflict), 16'(m_conf));
    end
  end

  task automatic put(input logic [15:0] v);
    @(negedge clk);
    ang_in = v; ang_vld = 1'b1;
    @(negedge clk);
    ang_vld = 1'b0;
  endtask

  task automatic rd(input bit hi, output logic [7:0] d);
    @(negedge clk);
    if (hi) msb_en_n = 1'b0; else lsb_en_n = 1'b0;
    repeat (EN) @(negedge clk);
    d = bus_out;
    msb_en_n = 1'b1; lsb_en_n = 1'b1;
    repeat (DIS + 1) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  logic [7:0]  d;
  logic [15:0] last;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(bus_oe == 8'h00, "R11", "oe after reset", 16'(bus_oe), 16'h0);
    chk(conflict == 1'b0, "R11", "conflict after reset", 16'(conflict), 16'h0);
    rd(1'b1, d);
    chk(d == 8'h00, "R11", "held cleared", 16'(d), 16'h0);

    // R2/R5/R6: transparent copy and both bytes at each resolution
    put(16'h5A6D);
    repeat (2) @(negedge clk);
    rd(1'b1, d);
    chk(d == 8'h5A, "R5", "high byte", 16'(d), 16'h5A);
    res_sel = 2'd0; rd(1'b0, d);
    chk(d == 8'h40, "R6", "low byte res10", 16'(d), 16'h40);
    res_sel = 2'd1; rd(1'b0, d);
    chk(d == 8'h60, "R6", "low byte res12", 16'(d), 16'h60);
    res_sel = 2'd2; rd(1'b0, d);
    chk(d == 8'h6C, "R6", "low byte res14", 16'(d), 16'h6C);
    res_sel = 2'd3; rd(1'b0, d);
    chk(d == 8'h6D, "R6", "low byte res16", 16'(d), 16'h6D);
    put(16'hC3F1);
    repeat (2) @(negedge clk);
    rd(1'b1, d);
    chk(d == 8'hC3, "R2", "copy follows new word", 16'(d), 16'hC3);

    // R4/R10: words strobed on each edge after the hold request
    put(16'h1111);
    @(negedge clk);
    hold_req = 1'b1; ang_in = 16'h2222; ang_vld = 1'b1;   // edge 1
    @(negedge clk); ang_in = 16'h3344;                    // edge 2: last loaded
    @(negedge clk); ang_in = 16'h5566;                    // edge 3: closing edge
    // R3: long hold with the live word changing every clock
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      ang_in = 16'(16'h7000 + k * 13);
      last = ang_in;
    end
    @(negedge clk); ang_vld = 1'b0;
    rd(1'b1, d);
    chk(d == 8'h33, "R10", "frozen high byte", 16'(d), 16'h33);
    rd(1'b0, d);
    chk(d == 8'h44, "R4", "frozen low byte", 16'(d), 16'h44);
    repeat (50) @(negedge clk);
    rd(1'b1, d);
    chk(d == 8'h33, "R3", "still frozen", 16'(d), 16'h33);

    // R1: release exposes the word tracked during the hold
    hold_req = 1'b0;
    repeat (FD + 2) @(negedge clk);
    rd(1'b1, d);
    chk(d == last[15:8], "R1", "tracked high byte", 16'(d), 16'(last[15:8]));
    rd(1'b0, d);
    chk(d == last[7:0], "R1", "tracked low byte", 16'(d), 16'(last[7:0]));

    // R8: driver turn-on and turn-off latency
    @(negedge clk); msb_en_n = 1'b0;
    @(negedge clk);
    chk(bus_oe == 8'h00, "R8", "not on before EN", 16'(bus_oe), 16'h0);
    @(negedge clk);
    chk(bus_oe == 8'hFF, "R8", "on at EN", 16'(bus_oe), 16'hFF);
    msb_en_n = 1'b1;
    repeat (DIS - 1) @(negedge clk);
    chk(bus_oe == 8'hFF, "R8", "still on before DIS", 16'(bus_oe), 16'hFF);
    @(negedge clk);
    chk(bus_oe == 8'h00, "R8", "off at DIS", 16'(bus_oe), 16'h0);

    // R9: both enables low
    chk(conflict == 1'b0, "R9", "no conflict yet", 16'(conflict), 16'h0);
    @(negedge clk); msb_en_n = 1'b0; lsb_en_n = 1'b0;
    repeat (EN) @(negedge clk);
    chk(bus_out == last[15:8], "R9", "high byte wins", 16'(bus_out), 16'(last[15:8]));
    chk(conflict == 1'b1, "R9", "conflict set", 16'(conflict), 16'h1);
    msb_en_n = 1'b1; lsb_en_n = 1'b1;
    repeat (DIS + 1) @(negedge clk);
    chk(conflict == 1'b1, "R9", "conflict sticky", 16'(conflict), 16'h1);
    chk(bus_oe == 8'h00, "R7", "idle bus released", 16'(bus_oe), 16'h0);
    chk(bus_out == 8'h00, "R7", "idle data zero", 16'(bus_out), 16'h0);

    // R11: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(conflict == 1'b0, "R11", "conflict cleared", 16'(conflict), 16'h0);
    rd(1'b0, d);
    chk(d == 8'h00, "R11", "held cleared again", 16'(d), 16'h0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule